// File: doc/BRIEF.md
# Largest-Value Counter Flush Engine

This block holds a bank of narrow statistics counters that sit in fast on-chip storage and act as a cache in front of wide counters kept in a slow memory. The slow memory can take only one read-modify-write every `SLOT_DIV` cycles. Each cycle the block may receive one increment, made of a valid bit and a counter index. It adds one to the addressed narrow counter. A packet that touches several counters presents them as a series of increments, one per cycle.

Once every `SLOT_DIV` cycles the block looks at all narrow counters and picks the one holding the largest value. It issues a flush command with that counter's index and value, and it clears the counter. The slow memory adds the flushed value into its wide counter. Always draining the fullest counter first keeps the narrow width small, roughly log2(b·(2 + ln N)) bits. The default width is derived this way. If the traffic ever pushes a narrow counter past its range, the counter holds at its maximum and a sticky overflow flag is raised. This flag tells software that the wide totals can no longer be trusted.

Top module: `lcf_stat_flusher`

## Requirements
- R1: While `rst_n` is low at a clock edge, every narrow counter, `flush_valid` and `overflow` return to zero.
- R2: An increment with `inc_valid` high adds exactly one to the counter named by `inc_idx`, and no other counter changes.
- R3: Flush opportunities come on every `SLOT_DIV`-th clock edge after reset is released, starting with edge number `SLOT_DIV`. `flush_valid` is high for one cycle after such an edge and is never high after any other edge.
- R4: At a flush opportunity the block reports the index and the value of the largest counter, as they were before that edge, on `flush_idx` and `flush_value`. It then clears that counter.
- R5: When several counters share the largest value, the one with the lowest index is flushed.
- R6: When all counters are zero at a flush opportunity, no flush is issued (`flush_valid` stays low).
- R7: An increment to the counter that is being flushed on the same edge leaves that counter at one.
- R8: An increment to a counter already at its maximum value (all ones) leaves it at the maximum and sets `overflow`. The exception is when the same edge flushes that counter, which falls under R7.
- R9: Once set, `overflow` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_valid | input | 1 | An increment is presented this cycle |
| inc_idx | input | IDX_W | Index of the counter to increment |
| flush_valid | output | 1 | A flush command is presented this cycle |
| flush_idx | output | IDX_W | Index of the flushed counter |
| flush_value | output | CTR_W | Value to be added into the wide counter |
| overflow | output | 1 | Sticky flag: a narrow counter saturated |

## Verification
Some checks run on every cycle. The assertions check that the selection tree's result bounds every counter, matches the value stored at the reported index and never skips a lower index holding the same value. They check that counters step by one, clear on a flush, land on one when a flush meets an increment, and hold at maximum while raising the sticky flag. They also check that two flushes are never closer than `SLOT_DIV` cycles apart. Other behaviour only the bench scenarios can show. These are the exact edge on which each flush appears, the absence of flushes while all counters are zero, and the tie-break between equal counters. The bench also shows the whole flush sequence under bursts, packet-like update series and round-robin load that drives counters into saturation.

// File: rtl/lcf_pkg.sv
// Shared constants and helpers for the largest-value counter flush engine.
// Assumes: callers pass N >= 2 and b >= 2.
package lcf_pkg;

    localparam int DEF_N_CTRS   = 16;
    localparam int DEF_SLOT_DIV = 4;

    // Integer estimate of log2(b * (2 + ln n)), with ln n taken as 0.693 * ceil(log2 n).
    function automatic int narrow_width(input int n, input int b);
        int scaled;
        scaled = (b * (2000 + 693 * $clog2(n)) + 999) / 1000;
        return $clog2(scaled + 1);
    endfunction

endpackage

// File: rtl/lcf_slot_timer.sv
// Slot timer: divides the clock into frames of SLOT_DIV cycles and marks
// the last cycle of each frame as a flush opportunity.
// Assumes: SLOT_DIV >= 2; synchronous active-low reset.
module lcf_slot_timer #(
    parameter int SLOT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_last
);
    localparam int SLOT_W = $clog2(SLOT_DIV);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_DIV - 1);

    logic [SLOT_W-1:0] slot_q;

    // Count slot positions and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Flag the final slot of the frame.
    always_comb begin
        slot_last = (slot_q == LAST_SLOT);
    end

    initial begin
        p_div_legal_r3: assert (SLOT_DIV >= 2)
            else $error("SLOT_DIV must be at least 2");
    end
endmodule

// File: rtl/lcf_ctr_bank.sv
// Counter bank: N_CTRS narrow saturating counters with one increment port
// and one clear port per cycle, plus a sticky overflow flag.
// Assumes: a clear and an increment to the same counter on one edge leave it at one;
// indices beyond N_CTRS-1 address nothing.
module lcf_ctr_bank #(
    parameter int N_CTRS = 16,
    parameter int CTR_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc_valid,
    input  logic [IDX_W-1:0]              inc_idx,
    input  logic                          clr_valid,
    input  logic [IDX_W-1:0]              clr_idx,
    output logic [N_CTRS-1:0][CTR_W-1:0]  cnt_out,
    output logic                          overflow
);
    localparam logic [CTR_W-1:0] CNT_MAX = '1;
    localparam logic [CTR_W-1:0] CNT_ONE = CTR_W'(1);

    logic [CTR_W-1:0]  cnt_q [N_CTRS];
    logic [N_CTRS-1:0] sat_hit;
    logic              ovf_q;

    for (genvar i = 0; i < N_CTRS; i++) begin : g_ctr
        logic hit_inc;
        logic hit_clr;

        // Decode whether this counter is addressed by the increment or the clear.
        always_comb begin
            hit_inc    = inc_valid && (inc_idx == IDX_W'(i));
            hit_clr    = clr_valid && (clr_idx == IDX_W'(i));
            sat_hit[i] = hit_inc && !hit_clr && (cnt_q[i] == CNT_MAX);
        end

        // Update one narrow counter: clear wins, a coincident increment leaves one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
            end else if (hit_clr) begin
                cnt_q[i] <= hit_inc ? CNT_ONE : '0;
            end else if (hit_inc && (cnt_q[i] != CNT_MAX)) begin
                cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end

        // Present the counter on the packed output bus.
        assign cnt_out[i] = cnt_q[i];
    end

    // Record any saturated increment until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (|sat_hit) begin
            ovf_q <= 1'b1;
        end
    end

    assign overflow = ovf_q;

    // R2: a plain increment below maximum steps the counter by one.
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_valid && !(clr_valid && clr_idx == inc_idx) && cnt_q[inc_idx] != CNT_MAX)
        |=> (cnt_q[$past(inc_idx)] == $past(cnt_q[inc_idx]) + CNT_ONE));

    // R4: a flushed counter with no coincident increment ends at zero.
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !(inc_valid && inc_idx == clr_idx))
        |=> (cnt_q[$past(clr_idx)] == '0));

    // R7: a flush meeting an increment on the same counter leaves one.
    p_clear_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && inc_valid && inc_idx == clr_idx)
        |=> (cnt_q[$past(clr_idx)] == CNT_ONE));

    // R8: incrementing a full counter holds it at maximum and raises the flag.
    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_valid && !(clr_valid && clr_idx == inc_idx) && cnt_q[inc_idx] == CNT_MAX)
        |=> (overflow && cnt_q[$past(inc_idx)] == CNT_MAX));

    // R9: the overflow flag never drops outside reset.
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/lcf_max_tree.sv
// Maximum finder: a balanced binary comparison tree that returns the largest
// counter value and its index; on equal values the lower index wins.
// Assumes: N_CTRS >= 2; purely combinational; unused leaves read as zero.
module lcf_max_tree #(
    parameter int N_CTRS = 16,
    parameter int CTR_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic [N_CTRS-1:0][CTR_W-1:0] vals,
    output logic [CTR_W-1:0]             max_val,
    output logic [IDX_W-1:0]             max_idx
);
    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [CTR_W-1:0] node_val [NODES];
    logic [IDX_W-1:0] node_idx [NODES];

    // Leaves: real counters, then zero padding up to a power of two.
    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        if (j < N_CTRS) begin : g_real
            assign node_val[LEAVES-1+j] = vals[j];
            assign node_idx[LEAVES-1+j] = IDX_W'(j);
        end else begin : g_pad
            assign node_val[LEAVES-1+j] = '0;
            assign node_idx[LEAVES-1+j] = '0;
        end
    end

    // Inner nodes: the right child wins only when strictly larger.
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_right;
        assign take_right  = node_val[2*k+2] > node_val[2*k+1];
        assign node_val[k] = take_right ? node_val[2*k+2] : node_val[2*k+1];
        assign node_idx[k] = take_right ? node_idx[2*k+2] : node_idx[2*k+1];
    end

    assign max_val = node_val[0];
    assign max_idx = node_idx[0];

    // R4 and R5: the tree result bounds every input, matches its own index,
    // and no lower index holds the same value.
    always_comb begin
        for (int i = 0; i < N_CTRS; i++) begin
            p_max_bound_r4: assert (max_val >= vals[i]);
            if (IDX_W'(i) < max_idx) begin
                p_low_tie_r5: assert (vals[i] < max_val);
            end
        end
        p_max_match_r4: assert (vals[max_idx] == max_val);
    end
endmodule

// File: rtl/lcf_stat_flusher.sv
// Largest-value counter flush engine (top). Counts increments in narrow counters
// and, on the last cycle of every SLOT_DIV-cycle frame, flushes the fullest counter
// to the wide-counter memory through a registered command.
// Assumes: at most one increment per cycle; the consumer accepts every flush command.
module lcf_stat_flusher
    import lcf_pkg::*;
#(
    parameter int N_CTRS   = DEF_N_CTRS,
    parameter int SLOT_DIV = DEF_SLOT_DIV,
    parameter int CTR_W    = narrow_width(N_CTRS, SLOT_DIV),
    parameter int IDX_W    = $clog2(N_CTRS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_valid,
    input  logic [IDX_W-1:0] inc_idx,
    output logic             flush_valid,
    output logic [IDX_W-1:0] flush_idx,
    output logic [CTR_W-1:0] flush_value,
    output logic             overflow
);
    localparam int GAP_W = $clog2(SLOT_DIV + 1);

    logic                         slot_last;
    logic [N_CTRS-1:0][CTR_W-1:0] cnt_bus;
    logic [CTR_W-1:0]             max_val;
    logic [IDX_W-1:0]             max_idx;
    logic                         do_flush;
    logic                         fv_q;
    logic [IDX_W-1:0]             fi_q;
    logic [CTR_W-1:0]             fval_q;
    logic [GAP_W-1:0]             gap_q;

    lcf_slot_timer #(
        .SLOT_DIV (SLOT_DIV)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_last (slot_last)
    );

    lcf_ctr_bank #(
        .N_CTRS (N_CTRS),
        .CTR_W  (CTR_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_valid (inc_valid),
        .inc_idx   (inc_idx),
        .clr_valid (do_flush),
        .clr_idx   (max_idx),
        .cnt_out   (cnt_bus),
        .overflow  (overflow)
    );

    lcf_max_tree #(
        .N_CTRS (N_CTRS),
        .CTR_W  (CTR_W),
        .IDX_W  (IDX_W)
    ) u_max (
        .vals    (cnt_bus),
        .max_val (max_val),
        .max_idx (max_idx)
    );

    // Flush only in the frame's last slot and only when some counter is non-zero.
    always_comb begin
        do_flush = slot_last && (max_val != '0);
    end

    // Register the flush command toward the wide-counter memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fv_q   <= 1'b0;
            fi_q   <= '0;
            fval_q <= '0;
        end else begin
            fv_q <= do_flush;
            if (do_flush) begin
                fi_q   <= max_idx;
                fval_q <= max_val;
            end
        end
    end

    assign flush_valid = fv_q;
    assign flush_idx   = fi_q;
    assign flush_value = fval_q;

    // Track cycles since the last flush for the spacing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(SLOT_DIV);
        end else if (fv_q) begin
            gap_q <= '0;
        end else if (gap_q != GAP_W'(SLOT_DIV)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R3: two flushes are never closer than SLOT_DIV cycles.
    p_flush_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (gap_q >= GAP_W'(SLOT_DIV - 1)));
endmodule

// File: tb/tb_lcf_stat_flusher.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver steps a reference model and queues the expected
// flush for every clock edge; the monitor pops and compares after each edge.
module tb_lcf_stat_flusher;
    localparam int N     = 16;
    localparam int B     = 4;
    localparam int CW    = 2;
    localparam int IW    = 4;
    localparam int MAXV  = (1 << CW) - 1;

    typedef struct packed {
        logic        valid;
        logic [31:0] idx;
        logic [31:0] val;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inc_valid = 1'b0;
    logic [IW-1:0] inc_idx = '0;
    logic          flush_valid;
    logic [IW-1:0] flush_idx;
    logic [CW-1:0] flush_value;
    logic          overflow;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    mcnt [N];
    int    mslot    = 0;
    bit    movf     = 1'b0;
    exp_t  expq [$];
    string tagq [$];
    string cur_req  = "R1/R6";
    exp_t  got_e;
    string got_tag;
    logic [7:0] lfsr = 8'hA5;
    bit    done = 1'b0;

    lcf_stat_flusher #(
        .N_CTRS   (N),
        .SLOT_DIV (B),
        .CTR_W    (CW),
        .IDX_W    (IW)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .inc_valid   (inc_valid),
        .inc_idx     (inc_idx),
        .flush_valid (flush_valid),
        .flush_idx   (flush_idx),
        .flush_value (flush_value),
        .overflow    (overflow)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) mcnt[i] = 0;
        mslot = 0;
        movf  = 1'b0;
        expq.delete();
        tagq.delete();
    endtask

    // One clock: apply stimulus at a falling edge, predict the next rising edge.
    task automatic step(input bit v, input int idx);
        exp_t e;
        int   clr;
        int   best;
        inc_valid = v;
        inc_idx   = IW'(idx);
        e = '0;
        clr = -1;
        if (mslot == B - 1) begin
            best = 0;
            for (int i = 1; i < N; i++) if (mcnt[i] > mcnt[best]) best = i;
            if (mcnt[best] > 0) begin
                e.valid = 1'b1;
                e.idx   = best;
                e.val   = mcnt[best];
                clr     = best;
            end
        end
        if (clr >= 0) mcnt[clr] = 0;
        if (v) begin
            if (idx == clr)              mcnt[idx] = 1;
            else if (mcnt[idx] == MAXV)  movf = 1'b1;
            else                         mcnt[idx] = mcnt[idx] + 1;
        end
        mslot = (mslot == B - 1) ? 0 : mslot + 1;
        expq.push_back(e);
        tagq.push_back(cur_req);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 0);
    endtask

    task automatic align();
        while (mslot != 0) step(1'b0, 0);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        inc_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        chk(flush_valid == 1'b0, "R1 flush_valid in reset", int'(flush_valid), 0);
        chk(overflow == 1'b0, "R1 overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
    endtask

    // Monitor: compare the flush output against the queued prediction per edge.
    always begin
        @(posedge clk);
        #5;
        if (rst_n && expq.size() > 0) begin
            got_e   = expq.pop_front();
            got_tag = tagq.pop_front();
            if (got_e.valid || flush_valid) begin
                n_checks++;
                if (flush_valid !== got_e.valid ||
                    (got_e.valid && (int'(flush_idx) != int'(got_e.idx) ||
                                     int'(flush_value) != int'(got_e.val)))) begin
                    n_fail++;
                    $display("FAIL %s flush actual v=%0d idx=%0d val=%0d expected v=%0d idx=%0d val=%0d",
                             got_tag, flush_valid, flush_idx, flush_value,
                             got_e.valid, got_e.idx, got_e.val);
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // R1 and R6: counters start empty, so idle frames produce no flush.
        cur_req = "R1/R6";
        idle(12);
        chk(flush_valid == 1'b0, "R6 no flush while empty", int'(flush_valid), 0);

        // R2 and R4: a burst on one counter, flushed as it grows.
        cur_req = "R2/R4";
        for (int k = 0; k < 10; k++) step(1'b1, 5);
        idle(8);
        for (int k = 0; k < 3; k++) step(1'b1, 11);
        step(1'b1, 2);
        idle(16);

        // R5: two counters tied at one when the flush slot arrives; index 3 must win.
        cur_req = "R5";
        idle(80);
        align();
        step(1'b1, 9);
        step(1'b1, 3);
        idle(2);
        idle(8);

        // R7: the counter being flushed is incremented on the same edge.
        cur_req = "R7";
        idle(80);
        align();
        step(1'b1, 12);
        step(1'b1, 12);
        step(1'b1, 12);
        step(1'b1, 12);
        idle(8);

        // R3: packet-like series of ten updates on pseudo-random counters.
        cur_req = "R3/R4";
        for (int p = 0; p < 20; p++) begin
            for (int u = 0; u < 10; u++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                step(1'b1, int'(lfsr[3:0]));
            end
            idle(p % 3);
        end
        idle(100);

        // R8 and R9: round-robin load saturates counters and sets the sticky flag.
        do_reset();
        cur_req = "R8";
        chk(overflow == 1'b0, "R8 overflow clear before load", int'(overflow), 0);
        for (int k = 0; k < 192; k++) step(1'b1, k % N);
        chk(overflow == movf, "R8 overflow after saturation", int'(overflow), int'(movf));
        chk(overflow == 1'b1, "R8 overflow set", int'(overflow), 1);
        cur_req = "R9";
        idle(100);
        chk(overflow == 1'b1, "R9 overflow stays set", int'(overflow), 1);
        do_reset();
        chk(overflow == 1'b0, "R1/R9 overflow cleared by reset", int'(overflow), 0);
        cur_req = "R6";
        idle(8);

        chk(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule